// File: doc/BRIEF.md
# Gated Tick Divider

This block produces a clock-enable pulse for one peripheral. It does not generate a new clock. A fast reference clock drives it. A divide field sets the spacing between pulses, and a gate input switches the pulses on and off. The `tick` output is high for one reference cycle at the divided rate. Logic downstream uses it as a clock enable. The `active` flag is registered and shows that pulses are being produced.

A compile-time parameter sets how the divide field is read. The five settings are:
- silent: no pulses at all.
- plus-one: the period is the field value plus one.
- doubled: the period is twice the field value plus one.
- power-of-two: the period is two raised to the field value plus one.
- pass-through: a pulse on every cycle, for a peripheral that has no divider.

A second parameter removes the gate, so the block runs from reset. Software may rewrite the divide field while pulses are running. The interval already under way always ends at its old length. The new value is taken at the terminal count, so no shortened period appears.

Top module: `clk_tick_divider`

## Requirements
- R1: In plus-one mode (`MODE` = 1) the distance between consecutive `tick` pulses is `div_val` + 1 reference cycles, for every field value from 0 to the maximum.
- R2: In doubled mode (`MODE` = 2) the distance between consecutive pulses is 2 × (`div_val` + 1) cycles, for every field value.
- R3: In power-of-two mode (`MODE` = 3) the distance between consecutive pulses is 2^(`div_val` + 1) cycles, for every field value.
- R4: In silent mode (`MODE` = 0) `tick` and `active` stay 0 whatever the gate and divide inputs are.
- R5: In pass-through mode (`MODE` = 4) `tick` is high on every cycle after the first cycle in which `active` is high.
- R6: After a rising edge that samples `gate_en` = 0, both `tick` and `active` are 0, even if a terminal count was due on that edge. They stay 0 for as long as the gate stays low.
- R7: The first rising edge that samples `gate_en` = 1 sets `active` and clears the count. With period P, the first pulse follows the (P+1)-th rising edge, counting that first edge. This also holds when the gate is set again after being cleared.
- R8: A new `div_val` is latched only on the edge that ends an interval, or while the block is stopped. An interval already under way keeps its old length.
- R9: With `HAS_GATE` = 0 the `gate_en` input is ignored. `active` rises after the first edge following reset, and pulses follow.
- R10: While `rst_n` is low, `tick` and `active` are 0.
- R11: When the current period is 2 or more, `tick` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_en | input | 1 | 1 lets pulses run, 0 stops them (ignored when `HAS_GATE` = 0) |
| div_val | input | DIV_W | Divide field, read according to `MODE` |
| tick | output | 1 | Single-cycle enable pulse at the divided rate |
| active | output | 1 | Registered flag: pulses are being generated |

## Verification
Suppose the latched period, the counter or the run flag is wrong inside the block. The effect shows on `tick` within one divided period, as an interval of the wrong length. If the period is reloaded at the wrong moment, the interval in which the divisor changes comes out too short or too long. This is why each change test measures both the interval that is running and the one after it. A run flag that is stale shows one cycle after the gate edge, as a `tick` or `active` that should not be there, or as a first pulse that arrives one edge early or late.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

  // How the divide field is read
  typedef enum logic [2:0] {
    DM_SILENT = 3'd0,
    DM_PLUS1  = 3'd1,
    DM_TWICE  = 3'd2,
    DM_POW2   = 3'd3,
    DM_PASS   = 3'd4
  } div_mode_e;

  // Width needed to hold the largest period a mode can produce
  function automatic int period_width(div_mode_e m, int fw);
    case (m)
      DM_PLUS1: return fw + 1;
      DM_TWICE: return fw + 2;
      DM_POW2:  return (1 << fw) + 1;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/ckdiv_period.sv
module ckdiv_period
  import ckdiv_pkg::*;
#(
  parameter div_mode_e MODE  = DM_TWICE,
  parameter int        DIV_W = 4,
  parameter int        PER_W = 6
) (
  input  logic [DIV_W-1:0] field,
  output logic [PER_W-1:0] period
);

  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  // Period in reference cycles for a given field value
  function automatic logic [PER_W-1:0] decode(logic [DIV_W-1:0] f);
    case (MODE)
      DM_PLUS1: return PER_W'(f) + ONE;
      DM_TWICE: return (PER_W'(f) + ONE) << 1;
      DM_POW2:  return ONE << (int'(f) + 1);
      default:  return ONE;
    endcase
  endfunction

  assign period = decode(field);

endmodule

// File: rtl/ckdiv_gate.sv
module ckdiv_gate #(
  parameter bit HAS_GATE = 1'b1
) (
  input  logic gate_en,
  output logic run
);

  generate
    if (HAS_GATE) begin : g_gated
      assign run = gate_en;
    end else begin : g_free
      logic unused_gate_en;
      assign unused_gate_en = gate_en;
      assign run = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/ckdiv_count.sv
module ckdiv_count #(
  parameter int PER_W  = 6,
  parameter bit SILENT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] next_per,
  output logic             tick,
  output logic             active,
  output logic             counting,
  output logic             term,
  output logic [PER_W-1:0] cnt,
  output logic [PER_W-1:0] per
);

  logic             active_q;
  logic             tick_q;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] per_q;

  // Counting only once the start edge has loaded the period
  assign counting = run & active_q;
  assign term     = counting & (cnt_q == per_q - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tick_q   <= 1'b0;
      cnt_q    <= '0;
      per_q    <= PER_W'(1);
    end else begin
      active_q <= run & !SILENT;
      tick_q   <= term;
      if (!counting || term) begin
        cnt_q <= '0;
        per_q <= next_per;
      end else begin
        cnt_q <= cnt_q + PER_W'(1);
      end
    end
  end

  assign tick   = tick_q;
  assign active = active_q;
  assign cnt    = cnt_q;
  assign per    = per_q;

endmodule

// File: rtl/clk_tick_divider.sv
module clk_tick_divider
  import ckdiv_pkg::*;
#(
  parameter div_mode_e MODE     = DM_TWICE,
  parameter int        DIV_W    = 4,
  parameter bit        HAS_GATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick,
  output logic             active
);

  localparam int PER_W  = period_width(MODE, DIV_W);
  localparam bit SILENT = (MODE == DM_SILENT);

  // Named internal events, brought out for the checker
  logic             run_w;
  logic [PER_W-1:0] next_per_w;
  logic             counting_w;
  logic             term_w;
  logic [PER_W-1:0] cnt_w;
  logic [PER_W-1:0] per_w;

  ckdiv_gate #(.HAS_GATE(HAS_GATE)) u_gate (
    .gate_en (gate_en),
    .run     (run_w)
  );

  ckdiv_period #(.MODE(MODE), .DIV_W(DIV_W), .PER_W(PER_W)) u_period (
    .field  (div_val),
    .period (next_per_w)
  );

  ckdiv_count #(.PER_W(PER_W), .SILENT(SILENT)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .next_per (next_per_w),
    .tick     (tick),
    .active   (active),
    .counting (counting_w),
    .term     (term_w),
    .cnt      (cnt_w),
    .per      (per_w)
  );

endmodule

// File: rtl/ckdiv_checker.sv
module ckdiv_checker #(
  parameter int PER_W    = 6,
  parameter bit SILENT   = 1'b0,
  parameter bit PASS     = 1'b0,
  parameter bit HAS_GATE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_en,
  input logic             tick,
  input logic             active,
  input logic             counting,
  input logic             term,
  input logic [PER_W-1:0] cnt,
  input logic [PER_W-1:0] per
);

  AST_GATE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_GATE && !gate_en) |=> (!tick && !active)); // R6

  AST_TICK_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> active); // R7

  AST_SILENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    SILENT |-> (!tick && !active)); // R4

  AST_PASS_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (PASS && active && $past(active)) |-> tick); // R5

  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !term) |=> $stable(per)); // R8

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < per)); // R1

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && per > PER_W'(1)) |=> !tick); // R11

  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_GATE && !SILENT) |=> active); // R9

endmodule

bind clk_tick_divider ckdiv_checker #(
  .PER_W    (PER_W),
  .SILENT   (MODE == ckdiv_pkg::DM_SILENT),
  .PASS     (MODE == ckdiv_pkg::DM_PASS),
  .HAS_GATE (HAS_GATE)
) u_ckdiv_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .gate_en  (gate_en),
  .tick     (tick),
  .active   (active),
  .counting (counting_w),
  .term     (term_w),
  .cnt      (cnt_w),
  .per      (per_w)
);

// File: tb/test_clk_tick_divider.sv
module test_clk_tick_divider;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate = 1'b0;
  logic gate_ng = 1'b0;
  logic [3:0] div4 = '0;
  logic [2:0] div3 = '0;
  logic [4:0] tk;
  logic [4:0] act;
  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  // idx 0 plus-one, 1 doubled, 2 power-of-two, 3 silent, 4 pass-through without gate
  clk_tick_divider #(.MODE(ckdiv_pkg::DM_PLUS1), .DIV_W(4), .HAS_GATE(1'b1)) i_plus1 (
    .clk(clk), .rst_n(rst_n), .gate_en(gate), .div_val(div4), .tick(tk[0]), .active(act[0]));
  clk_tick_divider #(.MODE(ckdiv_pkg::DM_TWICE), .DIV_W(4), .HAS_GATE(1'b1)) i_clk_tick_divider (
    .clk(clk), .rst_n(rst_n), .gate_en(gate), .div_val(div4), .tick(tk[1]), .active(act[1]));
  clk_tick_divider #(.MODE(ckdiv_pkg::DM_POW2), .DIV_W(3), .HAS_GATE(1'b1)) i_pow2 (
    .clk(clk), .rst_n(rst_n), .gate_en(gate), .div_val(div3), .tick(tk[2]), .active(act[2]));
  clk_tick_divider #(.MODE(ckdiv_pkg::DM_SILENT), .DIV_W(4), .HAS_GATE(1'b1)) i_silent (
    .clk(clk), .rst_n(rst_n), .gate_en(gate), .div_val(div4), .tick(tk[3]), .active(act[3]));
  clk_tick_divider #(.MODE(ckdiv_pkg::DM_PASS), .DIV_W(4), .HAS_GATE(1'b0)) i_pass (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_ng), .div_val(div4), .tick(tk[4]), .active(act[4]));

  // Stimulus and expected interval table: instance, field, cycles between pulses
  localparam int NV = 12;
  localparam int V_IDX [NV] = '{0, 0, 0, 1, 1, 1, 2, 2, 2, 0, 1, 2};
  localparam int V_DIV [NV] = '{0, 5, 15, 0, 7, 15, 0, 3, 7, 9, 3, 5};
  localparam int V_EXP [NV] = '{1, 6, 16, 2, 16, 32, 2, 16, 256, 10, 8, 64};

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic set_div(input int idx, input int v);
    if (idx == 2) div3 = 3'(v);
    else div4 = 4'(v);
  endtask

  // Negedges from now until the first pulse on instance idx (0 if none within limit)
  task automatic wait_tick(input int idx, input int limit, output int n);
    n = 0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (tk[idx]) begin
        n = k;
        break;
      end
    end
  endtask

  // Stop, load a field, start, and measure the distance between the first two pulses
  task automatic run_interval(input int idx, input int v, output int iv);
    int a;
    int b;
    gate = 1'b0;
    set_div(idx, v);
    repeat (2) @(negedge clk);
    gate = 1'b1;
    wait_tick(idx, 600, a);
    wait_tick(idx, 600, b);
    iv = (a == 0) ? -1 : b;
    gate = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int iv;
    int n;
    int cnt_t;
    int cnt_a;
    // R10: reset state
    repeat (3) @(negedge clk);
    check(tk == 5'd0, "R10 tick in reset", int'(tk), 0);
    check(act == 5'd0, "R10 active in reset", int'(act), 0);
    rst_n = 1'b1;
    // R9: ungated pass-through instance starts on its own
    @(negedge clk);
    check(act[4] == 1'b1, "R9 active after first edge", int'(act[4]), 1);
    cnt_t = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tk[4]) cnt_t++;
    end
    check(cnt_t == 20, "R5 pass-through every cycle", cnt_t, 20);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      run_interval(V_IDX[i], V_DIV[i], iv);
      check(iv == V_EXP[i], (V_IDX[i] == 0) ? "R1 table" : (V_IDX[i] == 1) ? "R2 table" : "R3 table",
            iv, V_EXP[i]);
    end

    // Full sweeps of the field range
    for (int v = 0; v < 16; v++) begin
      run_interval(0, v, iv);
      check(iv == v + 1, "R1 sweep", iv, v + 1);
    end
    for (int v = 0; v < 16; v++) begin
      run_interval(1, v, iv);
      check(iv == v + v + 2, "R2 sweep", iv, v + v + 2);
    end
    for (int v = 0; v < 8; v++) begin
      run_interval(2, v, iv);
      check(iv == 2 ** (v + 1), "R3 sweep", iv, 2 ** (v + 1));
    end

    // R7: first pulse latency, plus-one field 3 (period 4)
    gate = 1'b0;
    div4 = 4'd3;
    repeat (2) @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    check(act[0] == 1'b1, "R7 active after start edge", int'(act[0]), 1);
    n = 1;
    while (!tk[0] && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(n == 5, "R7 first pulse edge", n, 5);

    // R6: clear the gate one cycle before a terminal count
    repeat (3) @(negedge clk);
    gate = 1'b0;
    @(negedge clk);
    check(tk[0] == 1'b0 && act[0] == 1'b0, "R6 stop at once", int'({tk[0], act[0]}), 0);
    cnt_t = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (tk[0] || tk[1] || tk[2] || act[0]) cnt_t++;
    end
    check(cnt_t == 0, "R6 quiet while gate low", cnt_t, 0);

    // R7: restart counts from zero
    gate = 1'b1;
    wait_tick(0, 50, n);
    check(n == 5, "R7 restart from zero", n, 5);

    // R8: shrink mid-interval on the doubled instance (field 2 -> 0)
    gate = 1'b0;
    div4 = 4'd2;
    repeat (2) @(negedge clk);
    gate = 1'b1;
    wait_tick(1, 100, n);
    repeat (2) @(negedge clk);
    div4 = 4'd0;
    wait_tick(1, 100, n);
    check(n + 2 == 6, "R8 old interval kept on shrink", n + 2, 6);
    wait_tick(1, 100, n);
    check(n == 2, "R8 new interval after shrink", n, 2);
    // R11: no back-to-back pulse with period 2
    @(negedge clk);
    check(tk[1] == 1'b0, "R11 single pulse", int'(tk[1]), 0);
    // R8: grow at the pulse (field 0 -> 7)
    wait_tick(1, 100, n);
    div4 = 4'd7;
    wait_tick(1, 100, n);
    check(n == 2, "R8 old interval kept on grow", n, 2);
    wait_tick(1, 100, n);
    check(n == 16, "R8 new interval after grow", n, 16);

    // R4: silent instance with gate high
    div4 = 4'd5;
    cnt_t = 0;
    cnt_a = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (tk[3]) cnt_t++;
      if (act[3]) cnt_a++;
    end
    check(cnt_t == 0, "R4 silent ticks", cnt_t, 0);
    check(cnt_a == 0, "R4 silent active", cnt_a, 0);
    gate = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule